// File: doc/BRIEF.md
# Compare and Extension Flag Unit

This combinational execution unit handles the compare, zero-extend and sign-extend operations of an integer core at three operand sizes: byte (8 bits), word (16 bits) and long (32 bits). It takes an operation code, a size code and two operands that are already fetched. The source operand may come from a register or an immediate; the unit sees only its value. It returns a result word with a write-enable, and a five-bit vector of next condition flags with a write mask that tells the flag register which bits to update.

Compare subtracts the source from the destination at the selected size. It produces all five flags and writes no result back. Zero-extend and sign-extend rewrite the upper half of the selected register width. They update N, Z and V and leave H and C alone. The interrupt mask flag is not part of the flag vector, so no operation here can change it. Decode, operand fetch and register writeback belong to the surrounding pipeline.

Top module: `cmpx_flag_unit`

## Requirements
- R1: Compare (op code 0) drives res_we_o low and res_o equal to dst_i, so the difference is never written back.
- R2: Compare at a legal size sets flag_mask_o to 5'b11111. N is the top bit of dst-src at that size and Z marks a zero difference. C is the unsigned borrow out of the top bit and V is signed overflow of the subtraction. Operand bits above the selected size are ignored.
- R3: Compare sets H to the borrow out of bit 3 at byte size, out of bit 11 at word size and out of bit 27 at long size.
- R4: Zero-extend (op code 1) at word size (size code 1) gives {dst_i[31:16], 8'h00, dst_i[7:0]}. At long size (size code 2) it gives {16'h0000, dst_i[15:0]}. In both cases res_we_o is high.
- R5: Sign-extend (op code 2) at word size fills bits 15 to 8 with dst_i[7] and keeps bits 31 to 16 and 7 to 0. At long size it fills bits 31 to 16 with dst_i[15]. In both cases res_we_o is high.
- R6: Zero-extend sets N=0 and V=0, sets Z when the result is zero over the selected size, and drives flag_mask_o = 5'b01110.
- R7: Sign-extend sets N to the top bit of the result at the selected size, sets Z from that result, sets V=0, and drives flag_mask_o = 5'b01110.
- R8: Op code 3, size code 3 with any op, and extension at byte size (size code 0) are no-ops: res_we_o=0, res_o=dst_i, flags_o=0 and flag_mask_o=0.
- R9: The flag vector is ordered {H,N,Z,V,C} from bit 4 down to bit 0. Any flag bit whose mask bit is 0 reads 0, so extensions never assert H or C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | 0 compare, 1 zero-extend, 2 sign-extend, 3 none |
| size_i | input | 2 | 0 byte, 1 word, 2 long, 3 none |
| dst_i | input | 32 | Destination register value |
| src_i | input | 32 | Source register or immediate value |
| res_o | output | 32 | Result word |
| res_we_o | output | 1 | Result is to be written back |
| flags_o | output | 5 | Next {H,N,Z,V,C} |
| flag_mask_o | output | 5 | Per-flag update enable, same order |

## Verification
On every input change, the checker confirms the following: compares never request writeback, extensions always leave the low byte intact and never touch H or C, and no flag reads 1 without its mask bit. It also checks that N tracks the result's top bit after a sign-extend. Exact flag values at each size need the bench's vectors, which pin the arithmetic to known operand pairs. These include the half-borrow position, overflow on a sign change and borrow on an unsigned wrap. The same holds for the fill pattern of each extension and the no-op encodings.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;
  typedef enum logic [1:0] {
    OP_CMP  = 2'd0,
    OP_EXTU = 2'd1,
    OP_EXTS = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SZ_B    = 2'd0,
    SZ_W    = 2'd1,
    SZ_L    = 2'd2,
    SZ_NONE = 2'd3
  } size_e;

  localparam int unsigned FLAG_W = 5;
  localparam int unsigned FL_H = 4;
  localparam int unsigned FL_N = 3;
  localparam int unsigned FL_Z = 2;
  localparam int unsigned FL_V = 1;
  localparam int unsigned FL_C = 0;

  localparam logic [FLAG_W-1:0] MASK_ALL = 5'b11111;
  localparam logic [FLAG_W-1:0] MASK_EXT = 5'b01110;
endpackage

// File: rtl/cmpx_sub_flags.sv
// Flags of a - b at one operand width; H is the borrow out of bit W-5.
module cmpx_sub_flags #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         h_o,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         c_o
);
  localparam int unsigned HB = W - 5;

  logic [W:0]    full_diff;
  logic [HB+1:0] half_diff;
  logic [W-1:0]  diff;

  always_comb begin
    full_diff = {1'b0, a_i} - {1'b0, b_i};
    half_diff = {1'b0, a_i[HB:0]} - {1'b0, b_i[HB:0]};
    diff      = full_diff[W-1:0];
    c_o       = full_diff[W];
    h_o       = half_diff[HB+1];
    n_o       = diff[W-1];
    z_o       = ~|diff;
    v_o       = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ diff[W-1]);
  end
endmodule

// File: rtl/cmpx_ext.sv
// Upper-half fill for word (bits 15:8) or long (bits 31:16).
module cmpx_ext #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] dst_i,
  input  logic          is_long_i,
  input  logic          sign_i,
  output logic [DW-1:0] res_o,
  output logic          n_o,
  output logic          z_o
);
  localparam int unsigned WW = DW / 2;
  localparam int unsigned BW = DW / 4;

  logic [BW-1:0] fill_w;
  logic [WW-1:0] fill_l;
  logic [DW-1:0] res_w;
  logic [DW-1:0] res_l;

  always_comb begin
    fill_w = sign_i ? {BW{dst_i[BW-1]}} : '0;
    fill_l = sign_i ? {WW{dst_i[WW-1]}} : '0;
    res_w  = {dst_i[DW-1:WW], fill_w, dst_i[BW-1:0]};
    res_l  = {fill_l, dst_i[WW-1:0]};
    res_o  = is_long_i ? res_l : res_w;
    // zero-extend always yields a non-negative value
    n_o    = sign_i & (is_long_i ? res_o[DW-1] : res_o[WW-1]);
    z_o    = is_long_i ? (res_o == '0) : (res_o[WW-1:0] == '0);
  end
endmodule

// File: rtl/cmpx_flag_unit.sv
module cmpx_flag_unit
  import cmpx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DW-1:0]     dst_i,
  input  logic [DW-1:0]     src_i,
  output logic [DW-1:0]     res_o,
  output logic              res_we_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] flag_mask_o
);
  localparam int unsigned BW     = DW / 4;
  localparam int unsigned N_SIZE = 3;

  logic [FLAG_W-1:0] cmp_fl [4];
  logic [DW-1:0]     ext_res;
  logic              ext_n;
  logic              ext_z;
  logic              ext_size_ok;
  logic              cmp_size_ok;

  for (genvar g = 0; g < N_SIZE; g++) begin : g_cmp
    localparam int unsigned SW = BW * (1 << g);
    logic h, n, z, v, c;
    cmpx_sub_flags #(.W(SW)) u_sub (
      .a_i (dst_i[SW-1:0]),
      .b_i (src_i[SW-1:0]),
      .h_o (h),
      .n_o (n),
      .z_o (z),
      .v_o (v),
      .c_o (c)
    );
    assign cmp_fl[g] = {h, n, z, v, c};
  end
  assign cmp_fl[3] = '0;

  cmpx_ext #(.DW(DW)) u_ext (
    .dst_i     (dst_i),
    .is_long_i (size_i == SZ_L),
    .sign_i    (op_i == OP_EXTS),
    .res_o     (ext_res),
    .n_o       (ext_n),
    .z_o       (ext_z)
  );

  assign cmp_size_ok = (size_i != SZ_NONE);
  assign ext_size_ok = (size_i == SZ_W) || (size_i == SZ_L);

  always_comb begin
    res_o       = dst_i;
    res_we_o    = 1'b0;
    flags_o     = '0;
    flag_mask_o = '0;
    unique case (op_e'(op_i))
      OP_CMP: begin
        if (cmp_size_ok) begin
          flags_o     = cmp_fl[size_i];
          flag_mask_o = MASK_ALL;
        end
      end
      OP_EXTU, OP_EXTS: begin
        if (ext_size_ok) begin
          res_o       = ext_res;
          res_we_o    = 1'b1;
          flags_o     = {1'b0, ext_n, ext_z, 1'b0, 1'b0};
          flag_mask_o = MASK_EXT;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmpx_flag_chk.sv
module cmpx_flag_chk
  import cmpx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic [1:0]        op_i,
  input logic [1:0]        size_i,
  input logic [DW-1:0]     dst_i,
  input logic [DW-1:0]     src_i,
  input logic [DW-1:0]     res_o,
  input logic              res_we_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic [FLAG_W-1:0] flag_mask_o
);
  localparam int unsigned BW = DW / 4;

  logic known;
  assign known = !$isunknown({op_i, size_i, dst_i, src_i});

  always_comb begin
    if (known) begin
      a_r1_cmp_no_write: assert (!(op_i == OP_CMP) || !res_we_o)
        else $error("compare requested writeback");
      a_r2_cmp_all_flags: assert (!(op_i == OP_CMP && size_i != SZ_NONE) || flag_mask_o == MASK_ALL)
        else $error("compare mask %b", flag_mask_o);
      a_r5_ext_low_kept: assert (!res_we_o || res_o[BW-1:0] == dst_i[BW-1:0])
        else $error("extension altered low byte");
      a_r6_extu_nonneg: assert (!(op_i == OP_EXTU) || !flags_o[FL_N])
        else $error("zero-extend set N");
      a_r7_exts_n_top: assert (!(op_i == OP_EXTS && size_i == SZ_L) || flags_o[FL_N] == res_o[DW-1])
        else $error("sign-extend N mismatch");
      a_r8_noop_quiet: assert (res_we_o || op_i == OP_CMP || flag_mask_o == '0)
        else $error("no-op touched flags");
      a_r9_masked_only: assert ((flags_o & ~flag_mask_o) == '0)
        else $error("flag set outside mask");
      a_r9_ext_h_c: assert (op_i == OP_CMP || (!flag_mask_o[FL_H] && !flag_mask_o[FL_C]))
        else $error("extension masked H or C");
    end
  end
endmodule

bind cmpx_flag_unit cmpx_flag_chk #(.DW(DW)) u_chk (
  .op_i        (op_i),
  .size_i      (size_i),
  .dst_i       (dst_i),
  .src_i       (src_i),
  .res_o       (res_o),
  .res_we_o    (res_we_o),
  .flags_o     (flags_o),
  .flag_mask_o (flag_mask_o)
);

// File: tb/tb_cmpx_flag_unit.sv
module tb_cmpx_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 23;

  logic        clk = 1'b0;
  logic [1:0]  op_i;
  logic [1:0]  size_i;
  logic [31:0] dst_i;
  logic [31:0] src_i;
  logic [31:0] res_o;
  logic        res_we_o;
  logic [4:0]  flags_o;
  logic [4:0]  flag_mask_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpx_flag_unit dut (
    .op_i        (op_i),
    .size_i      (size_i),
    .dst_i       (dst_i),
    .src_i       (src_i),
    .res_o       (res_o),
    .res_we_o    (res_we_o),
    .flags_o     (flags_o),
    .flag_mask_o (flag_mask_o)
  );

  // {req[3:0], op, size, dst, src, res, we, flags{H,N,Z,V,C}, mask}
  localparam logic [114:0] VEC [N_VEC] = '{
    {4'd2, 2'd0, 2'd0, 32'h1234_5678, 32'h0000_0078, 32'h1234_5678, 1'b0, 5'b00100, 5'b11111},
    {4'd3, 2'd0, 2'd0, 32'h0000_0010, 32'h0000_0001, 32'h0000_0010, 1'b0, 5'b10000, 5'b11111},
    {4'd2, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 1'b0, 5'b11001, 5'b11111},
    {4'd2, 2'd0, 2'd0, 32'h0000_0080, 32'h0000_0001, 32'h0000_0080, 1'b0, 5'b10010, 5'b11111},
    {4'd3, 2'd0, 2'd1, 32'h0000_1000, 32'h0000_0001, 32'h0000_1000, 1'b0, 5'b10000, 5'b11111},
    {4'd3, 2'd0, 2'd1, 32'hFFFF_0800, 32'h0000_0001, 32'hFFFF_0800, 1'b0, 5'b00000, 5'b11111},
    {4'd2, 2'd0, 2'd1, 32'h0000_7FFF, 32'h0000_FFFF, 32'h0000_7FFF, 1'b0, 5'b01011, 5'b11111},
    {4'd3, 2'd0, 2'd2, 32'h0800_0000, 32'h0000_0001, 32'h0800_0000, 1'b0, 5'b00000, 5'b11111},
    {4'd3, 2'd0, 2'd2, 32'h1000_0000, 32'h0000_0001, 32'h1000_0000, 1'b0, 5'b10000, 5'b11111},
    {4'd2, 2'd0, 2'd2, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 1'b0, 5'b10010, 5'b11111},
    {4'd1, 2'd0, 2'd2, 32'h0000_0005, 32'h0000_0005, 32'h0000_0005, 1'b0, 5'b00100, 5'b11111},
    {4'd4, 2'd1, 2'd1, 32'hAAAA_BBCC, 32'h0000_0000, 32'hAAAA_00CC, 1'b1, 5'b00000, 5'b01110},
    {4'd6, 2'd1, 2'd1, 32'h1234_FF00, 32'h0000_0000, 32'h1234_0000, 1'b1, 5'b00100, 5'b01110},
    {4'd4, 2'd1, 2'd2, 32'hFFFF_8001, 32'h0000_0000, 32'h0000_8001, 1'b1, 5'b00000, 5'b01110},
    {4'd6, 2'd1, 2'd2, 32'hDEAD_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 5'b00100, 5'b01110},
    {4'd5, 2'd2, 2'd1, 32'h0000_1280, 32'h0000_0000, 32'h0000_FF80, 1'b1, 5'b01000, 5'b01110},
    {4'd5, 2'd2, 2'd1, 32'hFFFF_AB7F, 32'h0000_0000, 32'hFFFF_007F, 1'b1, 5'b00000, 5'b01110},
    {4'd7, 2'd2, 2'd1, 32'h5555_FF00, 32'h0000_0000, 32'h5555_0000, 1'b1, 5'b00100, 5'b01110},
    {4'd7, 2'd2, 2'd2, 32'h0000_8000, 32'h0000_0000, 32'hFFFF_8000, 1'b1, 5'b01000, 5'b01110},
    {4'd7, 2'd2, 2'd2, 32'hFFFF_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 5'b00100, 5'b01110},
    {4'd8, 2'd1, 2'd0, 32'h1234_5678, 32'h0000_0000, 32'h1234_5678, 1'b0, 5'b00000, 5'b00000},
    {4'd8, 2'd3, 2'd1, 32'h8765_4321, 32'h0000_0001, 32'h8765_4321, 1'b0, 5'b00000, 5'b00000},
    {4'd8, 2'd0, 2'd3, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 1'b0, 5'b00000, 5'b00000}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    op_i = op; size_i = sz; dst_i = d; src_i = s;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    op_i = 2'd0; size_i = 2'd0; dst_i = '0; src_i = '0;
    #1;
    // initial idle state: byte compare of zeros, R2
    chk("R2", "idle flags", {27'd0, flags_o}, 32'h0000_0004);
    chk("R1", "idle we", {31'd0, res_we_o}, 32'd0);

    for (int i = 0; i < N_VEC; i++) begin
      logic [114:0] v;
      string r;
      v = VEC[i];
      r = req_name(v[114:111]);
      drive(v[110:109], v[108:107], v[106:75], v[74:43]);
      chk(r, "res", res_o, v[42:11]);
      chk(r, "we", {31'd0, res_we_o}, {31'd0, v[10]});
      chk(r, "flags", {27'd0, flags_o}, {27'd0, v[9:5]});
      chk(r, "mask", {27'd0, flag_mask_o}, {27'd0, v[4:0]});
    end

    // R2: bits above byte size ignored
    drive(2'd0, 2'd0, 32'hAB00_0012, 32'h0000_0012);
    chk("R2", "upper ignored flags", {27'd0, flags_o}, 32'h0000_0004);
    // R3: word H independent of bit 12+
    drive(2'd0, 2'd1, 32'h0000_F000, 32'h0000_0001);
    chk("R3", "word H", {31'd0, flags_o[4]}, 32'd1);
    // R9: sign-extend keeps H and C unmasked and clear
    drive(2'd2, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R9", "ext H/C mask", {30'd0, flag_mask_o[4], flag_mask_o[0]}, 32'd0);
    chk("R9", "ext H/C value", {30'd0, flags_o[4], flags_o[0]}, 32'd0);
    // R1: compare passes destination through unchanged
    drive(2'd0, 2'd2, 32'hCAFE_F00D, 32'h1111_1111);
    chk("R1", "cmp res", res_o, 32'hCAFE_F00D);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule